// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives 22-bit command words over a three-wire, write-only serial link and loads them into a small bank of configuration registers. A controller pulls an active-low select line low, presents one bit per rising edge of a serial clock, and then releases the select line. The release commits the word. The serial clock, data and select lines are asynchronous to the block, so all three are synchronised into the system clock domain and oversampled there.

Each word carries an 18-bit payload followed by a 4-bit register address. Both fields are sent most significant bit first. The bank holds five registers:

- a main configuration word, which supplies a 3-bit auxiliary-output selector and an automatic power-up flag;
- a power-down word, with one enable per synthesizer path;
- three divider values, one for each of the two RF channels and one for the IF channel.

Loading either RF divider also makes that channel the active RF path. Each divider load raises a one-cycle strobe tagged with its channel, so downstream logic can start retuning.

Top module: `scfg_port`

## Requirements
- R1: After reset all register outputs are zero, the RF1 channel is active (`rf2_active` = 0) and `div_stb` is low.
- R2: A word is shifted in as payload bit 17 first down to payload bit 0, then address bit 3 down to address bit 0. It is written when `ser_en_n` rises. Address 0 loads the main configuration word: `cfg_aux_sel` shows payload bits 14:12 and `cfg_auto_up` shows payload bit 3.
- R3: Rising edges of `ser_clk` while `ser_en_n` is high shift nothing and do not count toward a word.
- R4: When more than 22 bits are shifted before `ser_en_n` rises, only the final 22 bits form the word.
- R5: When fewer than 22 bits are shifted before `ser_en_n` rises, the word is discarded and no register changes.
- R6: Address 2 loads the power-down word: payload bit 1 drives `pd_if_on` and payload bit 0 drives `pd_rf_on`.
- R7: Address 3 loads all 18 payload bits into `div_rf1` and clears `rf2_active`. Address 4 loads payload bits 16:0 into `div_rf2`, ignores bit 17, and sets `rf2_active`. Whichever of the two is written last decides the active channel.
- R8: Address 5 loads payload bits 15:0 into `div_if` and ignores bits 17:16.
- R9: Words addressed to 1 or to 6 through 15 are discarded and change no output.
- R10: Each write to address 3, 4 or 5 raises `div_stb` for exactly one system clock. `div_chan` gives the channel: 0 for RF1, 1 for RF2, 2 for IF. Writes to addresses 0 and 2 raise no strobe.
- R11: Words are accepted whatever the power-down word currently holds, including both paths off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Active-low serial select; its rising edge commits the word |
| cfg_aux_sel | output | 3 | Auxiliary output selector from the main configuration word |
| cfg_auto_up | output | 1 | Automatic power-up flag from the main configuration word |
| pd_if_on | output | 1 | IF path enable |
| pd_rf_on | output | 1 | RF path enable |
| div_rf1 | output | 18 | RF1 divider value |
| div_rf2 | output | 17 | RF2 divider value |
| div_if | output | 16 | IF divider value |
| rf2_active | output | 1 | 1 when RF2 is the active RF channel, 0 for RF1 |
| div_stb | output | 1 | One-cycle pulse on each divider write |
| div_chan | output | 2 | Channel of the divider write: 0 RF1, 1 RF2, 2 IF |

## Verification
The bench targets the following cases, each paired with the bug it would expose:

- **Clocks with the select line high.** A full valid word is clocked in while select is high, then select is pulsed with no further bits. A port that counts such clocks would commit a word that was never framed.
- **Long frames.** Frames with extra leading bits check that the word is taken from the newest 22 bits. A port that kept the oldest bits would load a shifted address and payload.
- **Short frames and reserved addresses.** These must leave every output and the strobe count untouched.
- **Channel selection order.** Interleaved RF1 and RF2 divider writes check last-writer-wins. Masked high bits on the RF2 and IF dividers catch a field that is too wide.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int DATA_W  = 18;
  localparam int ADDR_W  = 4;
  localparam int WORD_W  = DATA_W + ADDR_W;
  localparam int RF1_W   = 18;
  localparam int RF2_W   = 17;
  localparam int IF_W    = 16;
  localparam int AUX_LSB = 12;
  localparam int AUX_W   = 3;
  localparam int AUTO_BIT = 3;

  localparam logic [ADDR_W-1:0] A_MAIN = 4'd0;
  localparam logic [ADDR_W-1:0] A_PWR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_RF1  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RF2  = 4'd4;
  localparam logic [ADDR_W-1:0] A_IF   = 4'd5;

  typedef enum logic [1:0] {
    CH_RF1 = 2'd0,
    CH_RF2 = 2'd1,
    CH_IF  = 2'd2
  } chan_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);
  logic [WIDTH-1:0] stage [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign dout  = stage[STAGES-1];
  assign dprev = stage[STAGES];
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift
  import scfg_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         sclk_p,
  input  logic         sdat,
  input  logic         sen_n,
  input  logic         sen_n_p,
  output logic         wr_en,
  output logic [W-1:0] wr_word
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] bit_cnt;
  logic             clk_rise, en_rise;

  assign clk_rise = sclk & ~sclk_p;
  assign en_rise  = sen_n & ~sen_n_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_cnt <= '0;
      wr_en   <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_en <= 1'b0;
      if (en_rise) begin
        wr_en   <= (bit_cnt == CNT_W'(W));
        wr_word <= sh;
        bit_cnt <= '0;
      end else if (clk_rise && !sen_n) begin
        sh <= {sh[W-2:0], sdat};
        if (bit_cnt != CNT_W'(W)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sen_n && !en_rise) |=> $stable(bit_cnt)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt <= CNT_W'(W))); // R4
endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] main_q,
  output logic [1:0]        pwr_q,
  output logic [RF1_W-1:0]  rf1_q,
  output logic [RF2_W-1:0]  rf2_q,
  output logic [IF_W-1:0]   if_q,
  output logic              rf2_sel,
  output logic              stb,
  output logic [1:0]        chan
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              resv;

  assign addr = wr_word[ADDR_W-1:0];
  assign data = wr_word[WORD_W-1:ADDR_W];
  assign resv = !(addr inside {A_MAIN, A_PWR, A_RF1, A_RF2, A_IF});

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q  <= '0;
      pwr_q   <= '0;
      rf1_q   <= '0;
      rf2_q   <= '0;
      if_q    <= '0;
      rf2_sel <= 1'b0;
      stb     <= 1'b0;
      chan    <= CH_RF1;
    end else begin
      stb <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_MAIN: main_q <= data;
          A_PWR:  pwr_q  <= data[1:0];
          A_RF1: begin
            rf1_q   <= data[RF1_W-1:0];
            rf2_sel <= 1'b0;
            stb     <= 1'b1;
            chan    <= CH_RF1;
          end
          A_RF2: begin
            rf2_q   <= data[RF2_W-1:0];
            rf2_sel <= 1'b1;
            stb     <= 1'b1;
            chan    <= CH_RF2;
          end
          A_IF: begin
            if_q <= data[IF_W-1:0];
            stb  <= 1'b1;
            chan <= CH_IF;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb); // R10
  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    stb |-> (chan != 2'd3)); // R10
  AST_RF1_SELECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_RF1) |=> !rf2_sel); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rf2_sel)); // R7
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && resv) |=> ($stable(main_q) && $stable(pwr_q) && $stable(rf1_q)
                         && $stable(rf2_q) && $stable(if_q) && !stb)); // R9
endmodule

// File: rtl/scfg_port.sv
module scfg_port
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_en_n,
  output logic [AUX_W-1:0] cfg_aux_sel,
  output logic             cfg_auto_up,
  output logic             pd_if_on,
  output logic             pd_rf_on,
  output logic [RF1_W-1:0] div_rf1,
  output logic [RF2_W-1:0] div_rf2,
  output logic [IF_W-1:0]  div_if,
  output logic             rf2_active,
  output logic             div_stb,
  output logic [1:0]       div_chan
);
  logic [2:0]        s_cur, s_prv;
  logic              wr_en;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] main_q;
  logic [1:0]        pwr_q;

  scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ser_en_n, ser_data, ser_clk}),
    .dout (s_cur),
    .dprev(s_prv)
  );

  scfg_shift #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sclk   (s_cur[0]),
    .sclk_p (s_prv[0]),
    .sdat   (s_cur[1]),
    .sen_n  (s_cur[2]),
    .sen_n_p(s_prv[2]),
    .wr_en  (wr_en),
    .wr_word(wr_word)
  );

  scfg_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_word(wr_word),
    .main_q (main_q),
    .pwr_q  (pwr_q),
    .rf1_q  (div_rf1),
    .rf2_q  (div_rf2),
    .if_q   (div_if),
    .rf2_sel(rf2_active),
    .stb    (div_stb),
    .chan   (div_chan)
  );

  assign cfg_aux_sel = main_q[AUX_LSB +: AUX_W];
  assign cfg_auto_up = main_q[AUTO_BIT];
  assign pd_if_on    = pwr_q[1];
  assign pd_rf_on    = pwr_q[0];
endmodule

// File: tb/scfg_port_tb.sv
module scfg_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en_n = 1'b1;
  logic [2:0]  cfg_aux_sel;
  logic        cfg_auto_up, pd_if_on, pd_rf_on, rf2_active, div_stb;
  logic [17:0] div_rf1;
  logic [16:0] div_rf2;
  logic [15:0] div_if;
  logic [1:0]  div_chan;

  always #5 clk = ~clk;

  scfg_port u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en_n(ser_en_n), .cfg_aux_sel(cfg_aux_sel), .cfg_auto_up(cfg_auto_up),
    .pd_if_on(pd_if_on), .pd_rf_on(pd_rf_on), .div_rf1(div_rf1),
    .div_rf2(div_rf2), .div_if(div_if), .rf2_active(rf2_active),
    .div_stb(div_stb), .div_chan(div_chan)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // expected model
  logic [2:0]  e_aux = '0;
  logic        e_auto = 0, e_pif = 0, e_prf = 0, e_rf2act = 0;
  logic [17:0] e_rf1 = '0;
  logic [16:0] e_rf2 = '0;
  logic [15:0] e_if = '0;
  int e_cnt [3] = '{0, 0, 0};
  int o_cnt [3] = '{0, 0, 0};
  int wide_stb = 0;
  logic stb_prev = 0;

  always @(negedge clk) begin
    if (!rst && div_stb) begin
      if (div_chan < 2'd3) o_cnt[div_chan] = o_cnt[div_chan] + 1;
      if (stb_prev) wide_stb = wide_stb + 1;
    end
    stb_prev = div_stb;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] a, input logic [17:0] d);
    case (a)
      4'd0: begin e_aux = d[14:12]; e_auto = d[3]; end
      4'd2: begin e_pif = d[1]; e_prf = d[0]; end
      4'd3: begin e_rf1 = d; e_rf2act = 0; e_cnt[0]++; end
      4'd4: begin e_rf2 = d[16:0]; e_rf2act = 1; e_cnt[1]++; end
      4'd5: begin e_if = d[15:0]; e_cnt[2]++; end
      default: ;
    endcase
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      ser_clk = 1'b0;
      wclk(4);
      ser_clk = 1'b1;
      wclk(4);
    end
    ser_clk = 1'b0;
    wclk(4);
  endtask

  task automatic frame(input logic [63:0] v, input int n);
    ser_en_n = 1'b0;
    wclk(4);
    shift_bits(v, n);
    ser_en_n = 1'b1;
    wclk(10);
  endtask

  task automatic write(input logic [3:0] a, input logic [17:0] d);
    frame({42'd0, d, a}, 22);
    model(a, d);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " aux"},   32'(cfg_aux_sel), 32'(e_aux));
    chk({tag, " auto"},  32'(cfg_auto_up), 32'(e_auto));
    chk({tag, " pdif"},  32'(pd_if_on),    32'(e_pif));
    chk({tag, " pdrf"},  32'(pd_rf_on),    32'(e_prf));
    chk({tag, " rf1"},   32'(div_rf1),     32'(e_rf1));
    chk({tag, " rf2"},   32'(div_rf2),     32'(e_rf2));
    chk({tag, " if"},    32'(div_if),      32'(e_if));
    chk({tag, " sel"},   32'(rf2_active),  32'(e_rf2act));
    chk({tag, " R10 stb rf1"}, 32'(o_cnt[0]), 32'(e_cnt[0]));
    chk({tag, " R10 stb rf2"}, 32'(o_cnt[1]), 32'(e_cnt[1]));
    chk({tag, " R10 stb if"},  32'(o_cnt[2]), 32'(e_cnt[2]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    wclk(5);
    rst = 1'b0;
    wclk(8);
    check_all("R1 reset");
    chk("R1 stb low", 32'(div_stb), 32'd0);

    // R2 main config
    write(4'd0, 18'h0_7008);
    check_all("R2 main");
    // R6 power down
    write(4'd2, 18'h3_FFFE);
    check_all("R6 pwr");
    write(4'd2, 18'h0_0000);
    check_all("R6 pwr off");
    // R11 writable with both paths off
    write(4'd5, 18'h3_1BF3);
    check_all("R11 R8 if while off");
    // R7 channel ordering
    write(4'd3, 18'h2_AAAA);
    check_all("R7 rf1");
    write(4'd4, 18'h3_5555);
    check_all("R7 rf2 bit17 ignored");
    write(4'd3, 18'h1_2345);
    check_all("R7 rf1 last wins");
    // R9 reserved addresses
    write(4'd1, 18'h3_FFFF);
    check_all("R9 addr1");
    write(4'd15, 18'h3_FFFF);
    check_all("R9 addr15");
    // R3 clocks while enable high
    ser_en_n = 1'b1;
    wclk(4);
    shift_bits({42'd0, 18'h0_0ABC, 4'd4}, 22);
    ser_en_n = 1'b0;
    wclk(6);
    ser_en_n = 1'b1;
    wclk(10);
    check_all("R3 idle clocks");
    // R4 long frame
    frame({32'd0, 10'h2F3, 18'h0_1C2D, 4'd5}, 32);
    model(4'd5, 18'h0_1C2D);
    check_all("R4 long");
    // R5 short frame
    frame({43'd0, 18'h0_0777, 3'd2}, 21);
    check_all("R5 short");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [3:0]  a;
      logic [17:0] d;
      int lead, kind;
      kind = int'($urandom % 10);
      case ($urandom % 8)
        0: a = 4'd0; 1: a = 4'd2; 2: a = 4'd3; 3: a = 4'd4;
        4: a = 4'd5; 5: a = 4'd1; 6: a = 4'(6 + $urandom % 10); default: a = 4'd4;
      endcase
      d = 18'($urandom);
      lead = int'($urandom % 5);
      if (kind == 0) begin
        frame({42'd0, d, a} >> (lead + 1), 21 - lead);
        check_all("R5 rand short");
      end else begin
        frame((64'($urandom) << 22) | {42'd0, d, a}, 22 + lead);
        model(a, d);
        check_all("R4 R2 rand");
      end
    end
    chk("R10 stb width", 32'(wide_stb), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule